// File: doc/BRIEF.md
# Level-Crossing Trigger with Hysteresis

This block watches a stream of signed ADC samples. It emits a one-clock trigger strobe when the signal crosses a programmable threshold in the selected direction. The threshold is set by a signed 12-bit level value, read as a fraction of full scale (level/2048). For a 16-bit sample path, that puts the threshold at the level shifted left by four bits.

A fixed band of 20 sample counts on the near side of the threshold must be reached before the comparator arms again. Noise that hovers around the threshold therefore produces only one event per genuine crossing. A slope input picks rising or falling crossings, and an enable input gates the output. Level writes are clamped to the legal range. A write is applied only on a cycle that carries no sample, so one sample is never compared against two different thresholds.

Top module: `trig_level_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `trigOut` is 0. Reset sets the level to 0 and leaves the comparator disarmed.
- R2: The threshold is level × 2^(SAMPLE_W−12). With rising slope (`slopeFalling`=0), an armed comparator fires when a valid sample is ≥ the threshold. `trigOut` is high in the same cycle as that sample's `sampleValid` and is never high without `sampleValid`.
- R3: With rising slope, a valid sample ≤ threshold − 20 arms the comparator. A sample strictly between threshold − 20 and the threshold leaves the arm state unchanged.
- R4: Firing disarms the comparator. No further trigger occurs until the signal has again reached the arming band, so `trigOut` is never high on two consecutive cycles.
- R5: With falling slope (`slopeFalling`=1), a valid sample ≥ threshold + 20 arms the comparator, and an armed comparator fires on a valid sample ≤ the threshold.
- R6: While `trigEnable` is 0, `trigOut` stays 0. A crossing that happens while disabled still disarms the comparator, so re-enabling does not produce a late trigger.
- R7: The comparator starts disarmed. A signal that stays past the threshold without entering the arming band produces no trigger.
- R8: A level write on a cycle with `sampleValid`=0 takes effect at the end of that cycle. A write on a cycle with `sampleValid`=1 is held pending, with the newest pending write winning, and is applied on the next cycle without a sample. Samples before the apply use the old level. Every applied write disarms the comparator.
- R9: Written level values above 2047 are stored as 2047, and values below −2048 are stored as −2048.
- R10: A change of `slopeFalling` disarms the comparator. A sample in the cycle of the change cannot fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Qualifies `sampleData` in this cycle |
| sampleData | input | SAMPLE_W | Signed ADC sample |
| levelWrite | input | 1 | Write strobe for the level value |
| levelData | input | LEVEL_IN_W | Signed level value, clamped on write |
| slopeFalling | input | 1 | 0 selects rising crossings, 1 selects falling crossings |
| trigEnable | input | 1 | Allows triggers to appear on the output |
| trigOut | output | 1 | One-clock trigger strobe |

## Verification
The trigger decision has no register on its path. The result for each sample is therefore due in the same clock cycle as its `sampleValid`. The scoreboard compares it at the falling edge of that cycle against the item the driver queued when it applied the inputs.

Level writes and slope changes land on the rising edge that ends their cycle. The bench model applies them at that same point, so the first sample they can affect is the one driven on the following cycle. The pending-write, newest-wins and disarm cases are exercised by placing samples directly before and after the apply.

// File: rtl/trig_level_pkg.sv
package trig_level_pkg;

  // Strobes issued by the control to the datapath each cycle.
  typedef struct packed {
    logic captureLevel; // hold a level write that arrived with a sample
    logic loadFresh;    // apply the level being written this cycle
    logic loadPend;     // apply the held level
  } trigCtl_t;

  typedef enum logic {
    ST_DISARMED = 1'b0,
    ST_ARMED    = 1'b1
  } armState_t;

endpackage

// File: rtl/trig_level_dp.sv
module trig_level_dp
  import trig_level_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int LEVEL_W    = 12,
  parameter int LEVEL_IN_W = 16,
  parameter int HYST       = 20
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  trigCtl_t                     ctl,
  input  logic signed [SAMPLE_W-1:0]   sampleData,
  input  logic signed [LEVEL_IN_W-1:0] levelData,
  input  logic                         slopeFalling,
  output logic                         pendValid,
  output logic                         armZone,
  output logic                         fireZone,
  output logic signed [LEVEL_W-1:0]    levelQ
);

  localparam int SHIFT = SAMPLE_W - LEVEL_W;
  localparam int CMP_W = SAMPLE_W + 2;
  localparam int MAXV  = (2 ** (LEVEL_W - 1)) - 1;
  localparam int MINV  = -(2 ** (LEVEL_W - 1));
  localparam logic signed [CMP_W-1:0] HYST_W = CMP_W'(HYST);

  logic signed [LEVEL_W-1:0] clampVal;
  logic signed [LEVEL_W-1:0] pendQ;
  logic signed [CMP_W-1:0]   thrWide;
  logic signed [CMP_W-1:0]   sampleWide;

  // Saturate the incoming level to the legal signed range.
  generate
    if (LEVEL_IN_W > LEVEL_W) begin : gClamp
      localparam logic signed [LEVEL_IN_W-1:0] IN_MAX = LEVEL_IN_W'(MAXV);
      localparam logic signed [LEVEL_IN_W-1:0] IN_MIN = LEVEL_IN_W'(MINV);
      always_comb begin
        if (levelData > IN_MAX)      clampVal = LEVEL_W'(MAXV);
        else if (levelData < IN_MIN) clampVal = LEVEL_W'(MINV);
        else                         clampVal = levelData[LEVEL_W-1:0];
      end
    end else begin : gNoClamp
      assign clampVal = LEVEL_W'(levelData);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ    <= '0;
      pendQ     <= '0;
      pendValid <= 1'b0;
    end else if (ctl.loadFresh) begin
      levelQ    <= clampVal;
      pendValid <= 1'b0;
    end else if (ctl.loadPend) begin
      levelQ    <= pendQ;
      pendValid <= 1'b0;
    end else if (ctl.captureLevel) begin
      pendQ     <= clampVal;
      pendValid <= 1'b1;
    end
  end

  // Two guard bits keep threshold +/- hysteresis from wrapping.
  assign thrWide    = CMP_W'(levelQ) <<< SHIFT;
  assign sampleWide = CMP_W'(sampleData);

  always_comb begin
    if (slopeFalling) begin
      armZone  = sampleWide >= (thrWide + HYST_W);
      fireZone = sampleWide <= thrWide;
    end else begin
      armZone  = sampleWide <= (thrWide - HYST_W);
      fireZone = sampleWide >= thrWide;
    end
  end

endmodule

// File: rtl/trig_level_ctl.sv
module trig_level_ctl
  import trig_level_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sampleValid,
  input  logic     levelWrite,
  input  logic     slopeFalling,
  input  logic     trigEnable,
  input  logic     pendValid,
  input  logic     armZone,
  input  logic     fireZone,
  output trigCtl_t ctl,
  output logic     armed,
  output logic     trigOut
);

  armState_t stateQ, stateD;
  logic      slopePrev;
  logic      slopeChange;
  logic      fireHit;
  logic      anyLoad;

  assign slopeChange = slopeFalling ^ slopePrev;

  // Level writes reach the register only on sample-free cycles.
  assign ctl.captureLevel = sampleValid && levelWrite;
  assign ctl.loadFresh    = !sampleValid && levelWrite;
  assign ctl.loadPend     = !sampleValid && !levelWrite && pendValid;
  assign anyLoad          = ctl.loadFresh || ctl.loadPend;

  assign armed   = (stateQ == ST_ARMED);
  assign fireHit = sampleValid && armed && fireZone && !slopeChange;
  assign trigOut = fireHit && trigEnable;

  always_comb begin
    stateD = stateQ;
    if (anyLoad || slopeChange)        stateD = ST_DISARMED;
    else if (fireHit)                  stateD = ST_DISARMED;
    else if (sampleValid && armZone)   stateD = ST_ARMED;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_DISARMED;
      slopePrev <= 1'b0;
    end else begin
      stateQ    <= stateD;
      slopePrev <= slopeFalling;
    end
  end

endmodule

// File: rtl/trig_level_top.sv
module trig_level_top
  import trig_level_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int LEVEL_W    = 12,
  parameter int LEVEL_IN_W = 16,
  parameter int HYST       = 20
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sampleValid,
  input  logic signed [SAMPLE_W-1:0]   sampleData,
  input  logic                         levelWrite,
  input  logic signed [LEVEL_IN_W-1:0] levelData,
  input  logic                         slopeFalling,
  input  logic                         trigEnable,
  output logic                         trigOut
);

  trigCtl_t                  ctl;
  logic                      pendValid;
  logic                      armZone;
  logic                      fireZone;
  logic                      armed;
  logic signed [LEVEL_W-1:0] levelQ;

  trig_level_dp #(
    .SAMPLE_W  (SAMPLE_W),
    .LEVEL_W   (LEVEL_W),
    .LEVEL_IN_W(LEVEL_IN_W),
    .HYST      (HYST)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .sampleData  (sampleData),
    .levelData   (levelData),
    .slopeFalling(slopeFalling),
    .pendValid   (pendValid),
    .armZone     (armZone),
    .fireZone    (fireZone),
    .levelQ      (levelQ)
  );

  trig_level_ctl i_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .levelWrite  (levelWrite),
    .slopeFalling(slopeFalling),
    .trigEnable  (trigEnable),
    .pendValid   (pendValid),
    .armZone     (armZone),
    .fireZone    (fireZone),
    .ctl         (ctl),
    .armed       (armed),
    .trigOut     (trigOut)
  );

endmodule

// File: rtl/trig_level_chk.sv
module trig_level_chk
  import trig_level_pkg::*;
#(
  parameter int LEVEL_W = 12
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      sampleValid,
  input logic                      slopeFalling,
  input logic                      trigEnable,
  input logic                      trigOut,
  input logic                      armed,
  input trigCtl_t                  ctl,
  input logic signed [LEVEL_W-1:0] levelQ
);

  AST_TRIG_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> sampleValid); // R2

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |=> !trigOut); // R4

  AST_DISARM_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |=> !armed); // R4

  AST_TRIG_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !trigEnable |-> !trigOut); // R6

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> $stable(levelQ)); // R8

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.captureLevel |=> $stable(levelQ)); // R8

  AST_LOAD_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadFresh || ctl.loadPend) |=> !armed); // R8

  AST_SLOPE_DISARM: assert property (@(posedge clk) disable iff (!rstN)
    (slopeFalling != $past(slopeFalling)) |-> !trigOut); // R10

endmodule

bind trig_level_top trig_level_chk #(.LEVEL_W(LEVEL_W)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sampleValid (sampleValid),
  .slopeFalling(slopeFalling),
  .trigEnable  (trigEnable),
  .trigOut     (trigOut),
  .armed       (armed),
  .ctl         (ctl),
  .levelQ      (levelQ)
);

// File: tb/test_trig_level_top.sv
`timescale 1ns/1ps
module test_trig_level_top;

  localparam int SW  = 16;
  localparam int LIW = 16;
  localparam int HY  = 20;
  localparam int SCALE = 2 ** (SW - 12);

  logic                  clk = 1'b0;
  logic                  rstN;
  logic                  sampleValid;
  logic signed [SW-1:0]  sampleData;
  logic                  levelWrite;
  logic signed [LIW-1:0] levelData;
  logic                  slopeFalling;
  logic                  trigEnable;
  logic                  trigOut;

  always #2.5 clk = ~clk;

  trig_level_top i_trig_level_top (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .sampleData  (sampleData),
    .levelWrite  (levelWrite),
    .levelData   (levelData),
    .slopeFalling(slopeFalling),
    .trigEnable  (trigEnable),
    .trigOut     (trigOut)
  );

  typedef struct {
    bit    exp;
    string tag;
  } item_t;

  item_t q[$];
  int    nChecks = 0;
  int    nFails  = 0;
  bit    curSlope = 1'b0;
  bit    curEn    = 1'b1;

  // Reference state, kept from the requirements.
  int levelM = 0;
  int pendM  = 0;
  bit pendVM = 1'b0;
  bit armedM = 1'b0;
  bit slopePrevM = 1'b0;

  function automatic int clampLvl(int l);
    if (l > 2047)  return 2047;
    if (l < -2048) return -2048;
    return l;
  endfunction

  task automatic step(bit v, int s, bit wr, int lvl, string tag);
    bit armZ, fireZ, chg, fire, load;
    int thr;
    @(posedge clk);
    #1;
    sampleValid  = v;
    sampleData   = SW'(s);
    levelWrite   = wr;
    levelData    = LIW'(lvl);
    slopeFalling = curSlope;
    trigEnable   = curEn;
    thr   = levelM * SCALE;
    chg   = (curSlope != slopePrevM);
    armZ  = curSlope ? (s >= thr + HY) : (s <= thr - HY);
    fireZ = curSlope ? (s <= thr) : (s >= thr);
    fire  = v && armedM && fireZ && !chg;
    q.push_back('{fire && curEn, tag});
    load = !v && (wr || pendVM);
    if (load || chg)      armedM = 1'b0;
    else if (fire)        armedM = 1'b0;
    else if (v && armZ)   armedM = 1'b1;
    if (v && wr) begin
      pendM  = clampLvl(lvl);
      pendVM = 1'b1;
    end
    if (load) begin
      levelM = wr ? clampLvl(lvl) : pendM;
      pendVM = 1'b0;
    end
    slopePrevM = curSlope;
  endtask

  task automatic smp(int s, string tag);
    step(1'b1, s, 1'b0, 0, tag);
  endtask

  task automatic setLevel(int lvl, string tag);
    step(1'b0, 0, 1'b1, lvl, tag);
  endtask

  // Monitor: the trigger for a sample is due in the same cycle.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      nChecks++;
      if (trigOut !== it.exp) begin
        nFails++;
        $display("FAIL %s: trigOut actual=%b expected=%b", it.tag, trigOut, it.exp);
      end
    end
  end

  bit done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    sampleValid = 1'b0; sampleData = '0; levelWrite = 1'b0;
    levelData = '0; slopeFalling = 1'b0; trigEnable = 1'b1;
    // R1: output low while reset is held, even with a sample present
    repeat (2) @(posedge clk);
    #1 sampleValid = 1'b1; sampleData = 16'sd100;
    @(negedge clk);
    nChecks++;
    if (trigOut !== 1'b0) begin
      nFails++;
      $display("FAIL R1: trigOut actual=%b expected=0", trigOut);
    end
    @(posedge clk); #1 rstN = 1'b1; sampleValid = 1'b0;

    smp(100,  "R1 first sample after reset");
    // R7: parked past threshold 0, never armed
    smp(5000, "R7 steady above");
    smp(5000, "R7 steady above");
    smp(0,    "R7 at threshold, disarmed");
    // R3 / R2 at level 0
    smp(-20,  "R3 arm at thr-20");
    smp(0,    "R2 fire at thr");
    smp(0,    "R4 no refire");
    smp(-19,  "R3 thr-19 does not arm");
    smp(10,   "R3 no fire without arm");
    smp(-20,  "R3 arm");
    smp(-1,   "R2 below thr");
    smp(1,    "R2 fire above thr");

    // Level 100 -> threshold 1600
    setLevel(100, "R8 idle write");
    smp(1580, "R3 arm at 1580");
    smp(1599, "R2 just under thr");
    smp(1600, "R2 fire at 1600");
    smp(1590, "R4 inside band");
    smp(1610, "R4 no refire from band");
    smp(1500, "R3 rearm");
    smp(32767, "R2 fire full scale");

    // R8: applied write disarms
    smp(1000, "R8 arm");
    setLevel(100, "R8 rewrite same level");
    smp(1700, "R8 disarmed by write");

    // R8: write with a sample is held pending
    smp(1000, "R8 arm");
    step(1'b1, 1200, 1'b1, 10, "R8 write with sample");
    smp(1600, "R8 old level still used");
    step(1'b0, 0, 1'b0, 0, "R8 pending applied");
    smp(200,  "R8 disarmed, new thr 160");
    smp(140,  "R8 arm at new level");
    smp(160,  "R8 fire at new thr");

    // R8: newest pending write wins
    step(1'b1, 0, 1'b1, 50, "R8 pend 50");
    step(1'b1, 0, 1'b1, 30, "R8 pend 30");
    step(1'b0, 0, 1'b0, 0,  "R8 apply newest");
    smp(460, "R8 arm thr 480");
    smp(479, "R8 under thr");
    smp(480, "R8 fire at 480");

    // R10 / R5: falling slope
    smp(400, "R3 arm rising");
    curSlope = 1'b1;
    smp(470, "R10 slope change blocks fire");
    smp(499, "R5 thr+19 no arm");
    smp(480, "R5 no fire unarmed");
    smp(500, "R5 arm at thr+20");
    smp(481, "R5 above thr");
    smp(480, "R5 fire at thr");
    smp(470, "R4 no refire falling");

    // R6: enable gating
    smp(600, "R6 arm");
    curEn = 1'b0;
    smp(400, "R6 crossing while disabled");
    curEn = 1'b1;
    smp(400, "R6 no late trigger");
    smp(600, "R6 rearm");
    smp(300, "R6 fire enabled");

    // R9: clamping
    curSlope = 1'b0;
    setLevel(3000, "R9 write above range");
    smp(0,     "R9 arm");
    smp(32751, "R9 under clamped thr");
    smp(32752, "R9 fire at 2047*16");
    setLevel(-5000, "R9 write below range");
    curSlope = 1'b1;
    step(1'b0, 0, 1'b0, 0, "R10 slope change idle");
    smp(-32748, "R9 arm falling");
    smp(-32767, "R9 above clamped thr");
    smp(-32768, "R9 fire at -2048*16");
    curSlope = 1'b0;
    smp(-32768, "R9 rising cannot arm");
    smp(-32768, "R9 rising cannot fire");

    @(posedge clk);
    wait (q.size() == 0);
    @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule